// File: doc/BRIEF.md
# Segmented Two-Way Address Translator

This block turns the page part of a 32-bit effective address into a real page number. The top four address bits pick one of sixteen segment registers, and each register holds a 24-bit virtual segment identifier and two protection keys. Six address bits then name one of 64 sets in a two-way translation cache. Both ways of that set are compared at once against the segment identifier and the remaining page tag bits. A hit yields the real page number and four storage-attribute bits, unless the protection check fails or a store still has to set the entry's changed bit. In those two cases the block raises a fault or asks for a table search.

Software loads segment registers through a write port. Missing translations are refilled through a fill port, which chooses the way to replace. Any index can be invalidated with one command. Lookups have a fixed latency of one cycle. Reset clears only the response registers. Segment registers, entries, valid bits and replacement state keep their contents, so every index must be invalidated before translation is trusted.

Top module: `seg_tlb_top`

## Requirements
- R1: `lookupEpn` holds effective-address bits 0–19 (bit 0 is the MSB). `lookupEpn[19:16]` picks the segment register, `[15:10]` is the API tag, `[9:6]` is the EPI tag and `[5:0]` is the set. An entry hits only if it is valid and its stored VSID equals the selected segment register's VSID and its API and EPI match. `refillPage` uses the same layout without the segment bits.
- R2: `rspValid` is high in exactly the cycle after a cycle with `lookupValid` high, and low otherwise.
- R3: A hit that is permitted and needs no changed-bit update gives `{rspHit,rspFault,rspChgReq}=100` with the entry's RPN and WIMG. A miss gives `000` with RPN and WIMG zero.
- R4: The key is `segKs` when `lookupSuper=1` and `segKp` otherwise. PP 00 permits read and write only with key 0. PP 01 permits read and write with key 0 and read only with key 1. PP 10 permits both always. PP 11 permits read only. A violation gives `110` with RPN and WIMG zero.
- R5: A permitted store to an entry whose changed bit is 0 gives `101` (table-search request) with RPN and WIMG zero. A store to an entry whose changed bit is 1 completes as in R3.
- R6: A refill writes an invalid way first, way 0 before way 1. When both ways are valid it replaces the way named by the set's LRU bit, and afterwards the LRU bit names the other way.
- R7: Every hit, with no speculative qualifier, sets the set's LRU bit to the way not hit. Misses leave it unchanged.
- R8: An invalidate clears the valid bits of both ways of `invIdx` with no tag comparison, and leaves other sets untouched.
- R9: An invalidate and a lookup to the same set in the same cycle give a miss. An invalidate and a refill to the same set in the same cycle drop the refill.
- R10: Reset leaves segment registers, entries and valid bits unchanged.
- R11: Reset clears `rspValid`, `rspHit`, `rspFault` and `rspChgReq` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | Lookup request |
| lookupEpn | input | 20 | Effective address bits 0–19 |
| lookupStore | input | 1 | 1 = store, 0 = load |
| lookupSuper | input | 1 | 1 = supervisor privilege |
| segWrEn | input | 1 | Segment register write |
| segWrIdx | input | 4 | Segment register number |
| segWrVsid | input | 24 | Virtual segment identifier to store |
| segWrKs | input | 1 | Supervisor key to store |
| segWrKp | input | 1 | User key to store |
| refillEn | input | 1 | Refill request |
| refillPage | input | 16 | Effective address bits 4–19 of the new entry |
| refillVsid | input | 24 | VSID of the new entry |
| refillRpn | input | 20 | Real page number of the new entry |
| refillWimg | input | 4 | Storage attributes of the new entry |
| refillChg | input | 1 | Changed bit of the new entry |
| refillPp | input | 2 | Protection bits of the new entry |
| invEn | input | 1 | Invalidate request |
| invIdx | input | 6 | Set to invalidate |
| rspValid | output | 1 | Response strobe |
| rspHit | output | 1 | A way matched |
| rspFault | output | 1 | Protection violation |
| rspChgReq | output | 1 | Table search needed to set the changed bit |
| rspRpn | output | 20 | Real page number on completion, else 0 |
| rspWimg | output | 4 | Attributes on completion, else 0 |

## Verification
The assertions assume that the reset is held for at least one clock edge and that outputs are judged only while `rspValid` is high. They also assume that no page is refilled while an identical tag is already resident in the other way of its set, since a double match would make the way choice arbitrary. The stimulus first invalidates every index and writes every segment register in use. Each refill in the bench targets a page absent from its set, and same-cycle collisions happen only in the directed cases that are meant to test them.

// File: rtl/seg_tlb_pkg.sv
`timescale 1ns/1ps
package seg_tlb_pkg;
  localparam int SEG_W  = 4;
  localparam int API_W  = 6;
  localparam int EPI_W  = 4;
  localparam int SET_W  = 6;
  localparam int WAYS   = 2;
  localparam int VSID_W = 24;
  localparam int RPN_W  = 20;
  localparam int WIMG_W = 4;
  localparam int PP_W   = 2;

  localparam int PAGE_W  = API_W + EPI_W + SET_W;
  localparam int EPN_W   = SEG_W + PAGE_W;
  localparam int SEG_CNT = 1 << SEG_W;
  localparam int SET_CNT = 1 << SET_W;
  localparam int SET_LSB = 0;
  localparam int EPI_LSB = SET_W;
  localparam int API_LSB = SET_W + EPI_W;
  localparam int SEG_LSB = PAGE_W;

  localparam logic [PP_W-1:0] PP_KEY0_RW = 2'b00;
  localparam logic [PP_W-1:0] PP_OPEN    = 2'b10;

  typedef struct packed {
    logic [VSID_W-1:0] vsid;
    logic              ks;
    logic              kp;
  } seg_reg_t;

  typedef struct packed {
    logic [VSID_W-1:0] vsid;
    logic [API_W-1:0]  api;
    logic [EPI_W-1:0]  epi;
    logic [RPN_W-1:0]  rpn;
    logic [WIMG_W-1:0] wimg;
    logic              chg;
    logic [PP_W-1:0]   pp;
  } tlb_entry_t;

  typedef struct packed {
    logic             lookupKill;
    logic             lruHitWr;
    logic [SET_W-1:0] lruHitIdx;
    logic             lruHitVal;
    logic             fillWr;
    logic             fillWay;
    logic [SET_W-1:0] fillIdx;
    logic             lruFillVal;
    logic             invWr;
    logic [SET_W-1:0] invIdx;
  } ctrl_strb_t;
endpackage

// File: rtl/seg_tlb_ctrl.sv
`timescale 1ns/1ps
module seg_tlb_ctrl
  import seg_tlb_pkg::*;
(
  input  logic             lookupValid,
  input  logic [SET_W-1:0] lookupIdx,
  input  logic [WAYS-1:0]  hitWay,
  input  logic             refillEn,
  input  logic [SET_W-1:0] refillIdx,
  input  logic [WAYS-1:0]  fillValid,
  input  logic             fillLru,
  input  logic             invEn,
  input  logic [SET_W-1:0] invIdx,
  output ctrl_strb_t       strb
);
  logic hitLive;
  logic victim;
  logic invOnFill;

  // Victim: first invalid way, then the LRU bit.
  always_comb begin
    if (!fillValid[0])      victim = 1'b0;
    else if (!fillValid[1]) victim = 1'b1;
    else                    victim = fillLru;
  end

  assign invOnFill = invEn && (invIdx == refillIdx);

  always_comb begin
    strb            = '0;
    strb.invWr      = invEn;
    strb.invIdx     = invIdx;
    strb.lookupKill = invEn && (invIdx == lookupIdx);
    hitLive         = lookupValid && (|hitWay) && !strb.lookupKill;
    strb.lruHitWr   = hitLive;
    strb.lruHitIdx  = lookupIdx;
    // LRU bit names the way not just used.
    strb.lruHitVal  = hitWay[0];
    strb.fillWr     = refillEn && !invOnFill;
    strb.fillWay    = victim;
    strb.fillIdx    = refillIdx;
    strb.lruFillVal = !victim;
  end
endmodule

// File: rtl/seg_tlb_dp.sv
`timescale 1ns/1ps
module seg_tlb_dp
  import seg_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [EPN_W-1:0]  lookupEpn,
  input  logic              lookupStore,
  input  logic              lookupSuper,
  input  logic              segWrEn,
  input  logic [SEG_W-1:0]  segWrIdx,
  input  seg_reg_t          segWrData,
  input  logic [PAGE_W-1:0] refillPage,
  input  tlb_entry_t        refillData,
  input  ctrl_strb_t        strb,
  output logic [WAYS-1:0]   hitWay,
  output logic [WAYS-1:0]   fillValid,
  output logic              fillLru,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspFault,
  output logic              rspChgReq,
  output logic [RPN_W-1:0]  rspRpn,
  output logic [WIMG_W-1:0] rspWimg
);
  seg_reg_t                segFile [SEG_CNT];
  seg_reg_t                curSeg;
  logic [SET_W-1:0]        lookupIdx;
  logic [SET_W-1:0]        refillIdx;
  logic [API_W-1:0]        lookupApi;
  logic [EPI_W-1:0]        lookupEpi;
  tlb_entry_t [WAYS-1:0]   rdEnt;
  tlb_entry_t              selEnt;
  logic [SET_CNT-1:0]      lruQ;

  assign curSeg    = segFile[lookupEpn[SEG_LSB +: SEG_W]];
  assign lookupIdx = lookupEpn[SET_LSB +: SET_W];
  assign lookupApi = lookupEpn[API_LSB +: API_W];
  assign lookupEpi = lookupEpn[EPI_LSB +: EPI_W];
  assign refillIdx = refillPage[SET_LSB +: SET_W];

  // Segment registers: no reset.
  always_ff @(posedge clk) begin
    if (segWrEn) segFile[segWrIdx] <= segWrData;
  end

  for (genvar w = 0; w < WAYS; w++) begin : gWay
    tlb_entry_t         mem [SET_CNT];
    logic [SET_CNT-1:0] validQ;
    logic               fillHere;

    assign fillHere = strb.fillWr && (strb.fillWay == 1'(w));

    always_ff @(posedge clk) begin
      if (fillHere) mem[strb.fillIdx] <= refillData;
    end

    // Valid bits survive reset.
    always_ff @(posedge clk) begin
      if (fillHere)   validQ[strb.fillIdx] <= 1'b1;
      if (strb.invWr) validQ[strb.invIdx]  <= 1'b0;
    end

    assign rdEnt[w]     = mem[lookupIdx];
    assign hitWay[w]    = validQ[lookupIdx]
                          && (rdEnt[w].vsid == curSeg.vsid)
                          && (rdEnt[w].api == lookupApi)
                          && (rdEnt[w].epi == lookupEpi);
    assign fillValid[w] = validQ[refillIdx];
  end

  always_ff @(posedge clk) begin
    if (strb.lruHitWr) lruQ[strb.lruHitIdx] <= strb.lruHitVal;
    if (strb.fillWr)   lruQ[strb.fillIdx]   <= strb.lruFillVal;
  end
  assign fillLru = lruQ[refillIdx];

  logic anyHit, useKey, readOk, writeOk, faultNow, chgNow, doneNow;

  always_comb begin
    selEnt   = hitWay[0] ? rdEnt[0] : rdEnt[1];
    anyHit   = lookupValid && (|hitWay) && !strb.lookupKill;
    useKey   = lookupSuper ? curSeg.ks : curSeg.kp;
    readOk   = !((selEnt.pp == PP_KEY0_RW) && useKey);
    writeOk  = (selEnt.pp == PP_OPEN) || (!selEnt.pp[1] && !useKey);
    faultNow = anyHit && (lookupStore ? !writeOk : !readOk);
    chgNow   = anyHit && !faultNow && lookupStore && !selEnt.chg;
    doneNow  = anyHit && !faultNow && !chgNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspFault  <= 1'b0;
      rspChgReq <= 1'b0;
      rspRpn    <= '0;
      rspWimg   <= '0;
    end else begin
      rspValid  <= lookupValid;
      rspHit    <= anyHit;
      rspFault  <= faultNow;
      rspChgReq <= chgNow;
      rspRpn    <= doneNow ? selEnt.rpn  : '0;
      rspWimg   <= doneNow ? selEnt.wimg : '0;
    end
  end
endmodule

// File: rtl/seg_tlb_top.sv
`timescale 1ns/1ps
module seg_tlb_top
  import seg_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [EPN_W-1:0]  lookupEpn,
  input  logic              lookupStore,
  input  logic              lookupSuper,
  input  logic              segWrEn,
  input  logic [SEG_W-1:0]  segWrIdx,
  input  logic [VSID_W-1:0] segWrVsid,
  input  logic              segWrKs,
  input  logic              segWrKp,
  input  logic              refillEn,
  input  logic [PAGE_W-1:0] refillPage,
  input  logic [VSID_W-1:0] refillVsid,
  input  logic [RPN_W-1:0]  refillRpn,
  input  logic [WIMG_W-1:0] refillWimg,
  input  logic              refillChg,
  input  logic [PP_W-1:0]   refillPp,
  input  logic              invEn,
  input  logic [SET_W-1:0]  invIdx,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspFault,
  output logic              rspChgReq,
  output logic [RPN_W-1:0]  rspRpn,
  output logic [WIMG_W-1:0] rspWimg
);
  seg_reg_t        segWrData;
  tlb_entry_t      refillData;
  ctrl_strb_t      strb;
  logic [WAYS-1:0] hitWay;
  logic [WAYS-1:0] fillValid;
  logic            fillLru;

  assign segWrData = '{vsid: segWrVsid, ks: segWrKs, kp: segWrKp};
  assign refillData = '{vsid: refillVsid,
                        api:  refillPage[API_LSB +: API_W],
                        epi:  refillPage[EPI_LSB +: EPI_W],
                        rpn:  refillRpn,
                        wimg: refillWimg,
                        chg:  refillChg,
                        pp:   refillPp};

  seg_tlb_ctrl uCtrl (
    .lookupValid (lookupValid),
    .lookupIdx   (lookupEpn[SET_LSB +: SET_W]),
    .hitWay      (hitWay),
    .refillEn    (refillEn),
    .refillIdx   (refillPage[SET_LSB +: SET_W]),
    .fillValid   (fillValid),
    .fillLru     (fillLru),
    .invEn       (invEn),
    .invIdx      (invIdx),
    .strb        (strb)
  );

  seg_tlb_dp uDp (
    .clk         (clk),
    .rstN        (rstN),
    .lookupValid (lookupValid),
    .lookupEpn   (lookupEpn),
    .lookupStore (lookupStore),
    .lookupSuper (lookupSuper),
    .segWrEn     (segWrEn),
    .segWrIdx    (segWrIdx),
    .segWrData   (segWrData),
    .refillPage  (refillPage),
    .refillData  (refillData),
    .strb        (strb),
    .hitWay      (hitWay),
    .fillValid   (fillValid),
    .fillLru     (fillLru),
    .rspValid    (rspValid),
    .rspHit      (rspHit),
    .rspFault    (rspFault),
    .rspChgReq   (rspChgReq),
    .rspRpn      (rspRpn),
    .rspWimg     (rspWimg)
  );
endmodule

// File: rtl/seg_tlb_sva.sv
`timescale 1ns/1ps
module seg_tlb_sva
  import seg_tlb_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              lookupValid,
  input logic [EPN_W-1:0]  lookupEpn,
  input logic              lookupStore,
  input logic              invEn,
  input logic [SET_W-1:0]  invIdx,
  input logic              rspValid,
  input logic              rspHit,
  input logic              rspFault,
  input logic              rspChgReq,
  input logic [RPN_W-1:0]  rspRpn,
  input logic [WIMG_W-1:0] rspWimg
);
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> rspValid);

  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !rspValid);

  assert_miss_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (!rspFault && !rspChgReq && rspRpn == '0 && rspWimg == '0));

  assert_fault_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspHit && !rspChgReq && rspRpn == '0 && rspWimg == '0));

  assert_chg_only_store_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && !lookupStore) |=> !rspChgReq);

  assert_inv_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && invEn && invIdx == lookupEpn[SET_LSB +: SET_W]) |=> !rspHit);
endmodule

bind seg_tlb_top seg_tlb_sva uChk (.*);

// File: tb/seg_tlb_top_test.sv
`timescale 1ns/1ps
module seg_tlb_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [19:0] lookupEpn = '0;
  logic        lookupStore = 1'b0;
  logic        lookupSuper = 1'b0;
  logic        segWrEn = 1'b0;
  logic [3:0]  segWrIdx = '0;
  logic [23:0] segWrVsid = '0;
  logic        segWrKs = 1'b0;
  logic        segWrKp = 1'b0;
  logic        refillEn = 1'b0;
  logic [15:0] refillPage = '0;
  logic [23:0] refillVsid = '0;
  logic [19:0] refillRpn = '0;
  logic [3:0]  refillWimg = '0;
  logic        refillChg = 1'b0;
  logic [1:0]  refillPp = '0;
  logic        invEn = 1'b0;
  logic [5:0]  invIdx = '0;
  logic        rspValid, rspHit, rspFault, rspChgReq;
  logic [19:0] rspRpn;
  logic [3:0]  rspWimg;

  int errCnt = 0;
  int chkCnt = 0;
  bit runDone = 1'b0;

  always #2.5 clk = ~clk;

  seg_tlb_top uut (.*);

  function automatic logic [19:0] mkEpn(int seg, int api, int epi, int idx);
    return {4'(seg), 6'(api), 4'(epi), 6'(idx)};
  endfunction

  function automatic logic [23:0] segVsid(int seg);
    return 24'hC0_0000 | 24'(seg * 24'h0101);
  endfunction

  // kind = {hit, fault, chgReq}
  typedef struct packed {
    logic [19:0] epn;
    logic        st;
    logic        sup;
    logic [2:0]  kind;
    logic [19:0] rpn;
    logic [3:0]  wimg;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{mkEpn(0,1,2,5),  1'b0, 1'b0, 3'b100, 20'h11111, 4'h1},
    '{mkEpn(0,1,2,5),  1'b1, 1'b0, 3'b100, 20'h11111, 4'h1},
    '{mkEpn(0,1,3,5),  1'b0, 1'b0, 3'b100, 20'h22222, 4'h2},
    '{mkEpn(0,1,3,5),  1'b1, 1'b0, 3'b110, 20'h0,     4'h0},
    '{mkEpn(0,1,3,5),  1'b1, 1'b1, 3'b101, 20'h0,     4'h0},
    '{mkEpn(0,1,3,5),  1'b0, 1'b1, 3'b100, 20'h22222, 4'h2},
    '{mkEpn(3,4,0,9),  1'b0, 1'b1, 3'b110, 20'h0,     4'h0},
    '{mkEpn(3,4,0,9),  1'b0, 1'b0, 3'b110, 20'h0,     4'h0},
    '{mkEpn(2,7,7,63), 1'b1, 1'b1, 3'b110, 20'h0,     4'h0},
    '{mkEpn(2,7,7,63), 1'b0, 1'b0, 3'b100, 20'h44444, 4'h4},
    '{mkEpn(2,4,0,9),  1'b0, 1'b1, 3'b000, 20'h0,     4'h0},
    '{mkEpn(0,1,4,5),  1'b0, 1'b0, 3'b000, 20'h0,     4'h0},
    '{mkEpn(0,2,2,5),  1'b0, 1'b0, 3'b000, 20'h0,     4'h0},
    '{mkEpn(0,1,2,6),  1'b0, 1'b0, 3'b000, 20'h0,     4'h0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic segWrite(input int idx, input logic ks, input logic kp);
    @(negedge clk);
    segWrEn = 1'b1; segWrIdx = 4'(idx); segWrVsid = segVsid(idx); segWrKs = ks; segWrKp = kp;
    @(negedge clk);
    segWrEn = 1'b0;
  endtask

  task automatic refill(input logic [19:0] epn, input logic [19:0] rpn, input logic [3:0] wimg,
                        input logic chg, input logic [1:0] pp);
    @(negedge clk);
    refillEn = 1'b1; refillPage = epn[15:0]; refillVsid = segVsid(int'(epn[19:16]));
    refillRpn = rpn; refillWimg = wimg; refillChg = chg; refillPp = pp;
    @(negedge clk);
    refillEn = 1'b0;
  endtask

  task automatic inval(input int idx);
    @(negedge clk);
    invEn = 1'b1; invIdx = 6'(idx);
    @(negedge clk);
    invEn = 1'b0;
  endtask

  task automatic doLookup(input logic [19:0] epn, input logic st, input logic sup);
    @(negedge clk);
    lookupValid = 1'b1; lookupEpn = epn; lookupStore = st; lookupSuper = sup;
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  task automatic expectRsp(input string req, input logic [2:0] kind, input logic [19:0] rpn,
                           input logic [3:0] wimg);
    logic [27:0] act, exp;
    act = {rspValid, rspHit, rspFault, rspChgReq, rspRpn, rspWimg};
    exp = {1'b1, kind, rpn, wimg};
    check(act == exp, req, 64'(act), 64'(exp));
  endtask

  task automatic finishRun();
    runDone = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!runDone) begin
      errCnt++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      finishRun();
    end
  end

  initial begin
    logic [19:0] pX, pY, pZ, pW;
    repeat (2) @(negedge clk);
    // R11: response registers cleared during reset
    check({rspValid, rspHit, rspFault, rspChgReq} == 4'b0, "R11 reset state",
          64'({rspValid, rspHit, rspFault, rspChgReq}), 64'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < 64; i++) inval(i);
    for (int s = 0; s < 4; s++) segWrite(s, (s == 3), 1'b1);

    refill(mkEpn(0,1,2,5),  20'h11111, 4'h1, 1'b1, 2'b10);
    refill(mkEpn(0,1,3,5),  20'h22222, 4'h2, 1'b0, 2'b01);
    refill(mkEpn(3,4,0,9),  20'h33333, 4'h3, 1'b1, 2'b00);
    refill(mkEpn(2,7,7,63), 20'h44444, 4'h4, 1'b1, 2'b11);

    // Table walk: R1 misses, R3 completions, R4 faults, R5 changed-bit requests
    for (int v = 0; v < NV; v++) begin
      string req;
      doLookup(VECS[v].epn, VECS[v].st, VECS[v].sup);
      case (VECS[v].kind)
        3'b000:  req = "R1 table miss";
        3'b100:  req = "R3 table hit";
        3'b110:  req = "R4 table fault";
        default: req = "R5 table change";
      endcase
      expectRsp(req, VECS[v].kind, VECS[v].rpn, VECS[v].wimg);
    end

    // R2: strobe lasts one cycle only
    @(negedge clk);
    check(rspValid == 1'b0, "R2 strobe drops", 64'(rspValid), 64'h0);

    // R6 / R7 replacement in set 20
    pX = mkEpn(0,9,1,20); pY = mkEpn(0,9,2,20); pZ = mkEpn(0,9,3,20); pW = mkEpn(0,9,4,20);
    refill(pX, 20'h77777, 4'h8, 1'b1, 2'b10);
    refill(pY, 20'h12345, 4'h9, 1'b1, 2'b10);
    doLookup(pX, 1'b0, 1'b0);
    expectRsp("R7 hit X before refill", 3'b100, 20'h77777, 4'h8);
    refill(pZ, 20'h55555, 4'h6, 1'b1, 2'b10);
    doLookup(pX, 1'b0, 1'b0);
    expectRsp("R7 recently used X kept", 3'b100, 20'h77777, 4'h8);
    doLookup(pY, 1'b0, 1'b0);
    expectRsp("R6 LRU way Y evicted", 3'b000, 20'h0, 4'h0);
    doLookup(pZ, 1'b0, 1'b0);
    expectRsp("R6 new Z present", 3'b100, 20'h55555, 4'h6);
    doLookup(pY, 1'b0, 1'b0);
    expectRsp("R7 miss again", 3'b000, 20'h0, 4'h0);
    refill(pW, 20'h66666, 4'h7, 1'b1, 2'b10);
    doLookup(pX, 1'b0, 1'b0);
    expectRsp("R7 miss left LRU, X evicted", 3'b000, 20'h0, 4'h0);
    doLookup(pZ, 1'b0, 1'b0);
    expectRsp("R6 Z kept", 3'b100, 20'h55555, 4'h6);
    doLookup(pW, 1'b0, 1'b0);
    expectRsp("R6 W present", 3'b100, 20'h66666, 4'h7);

    // R8: index invalidate clears both ways
    inval(5);
    doLookup(mkEpn(0,1,2,5), 1'b0, 1'b0);
    expectRsp("R8 way A cleared", 3'b000, 20'h0, 4'h0);
    doLookup(mkEpn(0,1,3,5), 1'b0, 1'b0);
    expectRsp("R8 way B cleared", 3'b000, 20'h0, 4'h0);
    doLookup(mkEpn(2,7,7,63), 1'b0, 1'b0);
    expectRsp("R8 other set intact", 3'b100, 20'h44444, 4'h4);

    // R9: same-cycle invalidate against lookup
    @(negedge clk);
    lookupValid = 1'b1; lookupEpn = mkEpn(2,7,7,63); lookupStore = 1'b0; lookupSuper = 1'b0;
    invEn = 1'b1; invIdx = 6'd9;
    @(negedge clk);
    lookupValid = 1'b0; invEn = 1'b0;
    expectRsp("R9 other-set invalidate", 3'b100, 20'h44444, 4'h4);
    @(negedge clk);
    lookupValid = 1'b1; lookupEpn = mkEpn(2,7,7,63);
    invEn = 1'b1; invIdx = 6'd63;
    @(negedge clk);
    lookupValid = 1'b0; invEn = 1'b0;
    expectRsp("R9 invalidate wins", 3'b000, 20'h0, 4'h0);

    // R9: same-cycle invalidate drops refill
    @(negedge clk);
    refillEn = 1'b1; refillPage = mkEpn(0,5,5,40) & 20'hFFFF; refillVsid = segVsid(0);
    refillRpn = 20'h9ABCD; refillWimg = 4'hA; refillChg = 1'b1; refillPp = 2'b10;
    invEn = 1'b1; invIdx = 6'd40;
    @(negedge clk);
    refillEn = 1'b0; invEn = 1'b0;
    doLookup(mkEpn(0,5,5,40), 1'b0, 1'b0);
    expectRsp("R9 refill dropped", 3'b000, 20'h0, 4'h0);

    // R11 / R10: reset mid-run
    doLookup(pZ, 1'b0, 1'b0);
    rstN = 1'b0;
    #0.5;
    check({rspValid, rspHit} == 2'b00, "R11 async clear", 64'({rspValid, rspHit}), 64'h0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    doLookup(pZ, 1'b0, 1'b0);
    expectRsp("R10 entry survives reset", 3'b100, 20'h55555, 4'h6);
    doLookup(pW, 1'b1, 1'b1);
    expectRsp("R10 segment survives reset", 3'b100, 20'h66666, 4'h7);

    finishRun();
  end
endmodule